// File: doc/BRIEF.md
# TLB Refill Victim Selector

This block sits beside a software-managed translation buffer. Whenever a translation attempt fails, the page walker raises a one-cycle fault strobe, and the block records the fault for the refill handler. It says which buffer set the handler should overwrite, and it captures the access type, the faulting virtual page and the process identifier.

The victim set on a miss comes from a 16-bit pseudo-random shift register. The register starts from a fixed seed and moves forward one step on each fault, whether the fault was a miss or a permission failure. On a permission failure, the matching set is reported in place of the random set. Both result registers, plus the shift register itself, are brought out so that a handler or a bench can read them.

Top module: `tlb_victim_sel`

## Requirements
- R1: After reset the shift register reads 0xCCCC, and the selection and cause registers read zero.
- R2: The feedback bit is the even/odd parity of the shift register bitwise-ANDed with the tap mask 0x8805, taken over all 16 bits.
- R3: One step shifts the register right by one place, puts the feedback bit into bit 15 and keeps 16 bits.
- R4: The shift register steps exactly once on each clock edge where `fault_i` is high, whatever the value of `miss_i`, and holds on every other edge.
- R5: On a fault with `miss_i` high, selection bits 5:4 take bits 1:0 of the shift register as they were before that fault's step.
- R6: On a fault with `miss_i` low, selection bits 5:4 take `hit_set_i`.
- R7: On a fault, selection bits 3:0 take the low 4 bits of `vpn_i`, and the rest of the selection register is written from scratch.
- R8: On a fault, cause bits 7:0 take `pid_i`, bits 9:8 take `acc_type_i` unchanged, and bits 31:13 take the 19-bit `vpn_i`.
- R9: When `fault_i` is low, the selection and cause registers keep their values.
- R10: Cause bits 12:10 are not written by a fault and keep their reset value of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fault_i | input | 1 | High for one cycle for each failed translation |
| miss_i | input | 1 | 1 = no entry matched, 0 = an entry matched but a permission check failed |
| acc_type_i | input | 2 | Access-type code, stored as given |
| vpn_i | input | 19 | Faulting virtual page number |
| hit_set_i | input | 2 | Set that matched, used when `miss_i` is 0 |
| pid_i | input | 8 | Current process identifier |
| lfsr_o | output | 16 | Shift register state |
| sel_o | output | 6 | Selection register: {set, index} |
| cause_o | output | 32 | Cause register |

## Verification
The assertions take each cycle with `fault_i` high as a separate fault. They also take `miss_i`, `hit_set_i`, `vpn_i`, `pid_i` and `acc_type_i` to be valid in that cycle, and assume nothing about those inputs in any other cycle. The stimulus changes every input away from the clock edge. It puts faults back to back, separates them with idle gaps, and sets `hit_set_i` and the other fields to random values even in idle cycles, so that any capture outside a fault shows up.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
  localparam int unsigned DEF_RAND_W  = 16;
  localparam logic [15:0] DEF_SEED    = 16'hCCCC;
  localparam logic [15:0] DEF_TAPS    = 16'h8805;
  localparam int unsigned DEF_SET_W   = 2;
  localparam int unsigned DEF_IDX_W   = 4;
  localparam int unsigned DEF_VPN_W   = 19;
  localparam int unsigned DEF_PID_W   = 8;
  localparam int unsigned DEF_TYPE_W  = 2;
  localparam int unsigned DEF_CAUSE_W = 32;
endpackage

// File: rtl/tvs_rst_sync.sv
module tvs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/tvs_rand_gen.sv
module tvs_rand_gen #(
  parameter int unsigned         W    = 16,
  parameter logic [W-1:0]        SEED = '1,
  parameter logic [W-1:0]        TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = state_q;
    if (step_i) state_d = {fb, state_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/tvs_fault_ctx.sv
module tvs_fault_ctx #(
  parameter int unsigned SET_W   = 2,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned VPN_W   = 19,
  parameter int unsigned PID_W   = 8,
  parameter int unsigned TYPE_W  = 2,
  parameter int unsigned CAUSE_W = 32,
  localparam int unsigned SEL_W  = SET_W + IDX_W,
  localparam int unsigned TYPE_LO = PID_W,
  localparam int unsigned VPN_LO  = CAUSE_W - VPN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_i,
  input  logic               miss_i,
  input  logic [SET_W-1:0]   rand_set_i,
  input  logic [SET_W-1:0]   hit_set_i,
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic [PID_W-1:0]   pid_i,
  input  logic [TYPE_W-1:0]  acc_type_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [SET_W-1:0]   set_pick;

  always_comb begin
    set_pick = miss_i ? rand_set_i : hit_set_i;
    sel_d    = {set_pick, vpn_i[IDX_W-1:0]};
    cause_d  = cause_q;
    cause_d[PID_W-1:0]                 = pid_i;
    cause_d[TYPE_LO+TYPE_W-1:TYPE_LO]  = acc_type_i;
    cause_d[CAUSE_W-1:VPN_LO]          = vpn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      cause_q <= '0;
    end else if (fault_i) begin
      sel_q   <= sel_d;
      cause_q <= cause_d;
    end
  end

  assign sel_o   = sel_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tvs_pkg::*;
#(
  parameter int unsigned          RAND_W  = DEF_RAND_W,
  parameter logic [RAND_W-1:0]    SEED    = DEF_SEED,
  parameter logic [RAND_W-1:0]    TAPS    = DEF_TAPS,
  parameter int unsigned          SET_W   = DEF_SET_W,
  parameter int unsigned          IDX_W   = DEF_IDX_W,
  parameter int unsigned          VPN_W   = DEF_VPN_W,
  parameter int unsigned          PID_W   = DEF_PID_W,
  parameter int unsigned          TYPE_W  = DEF_TYPE_W,
  parameter int unsigned          CAUSE_W = DEF_CAUSE_W,
  localparam int unsigned         SEL_W   = SET_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_i,
  input  logic               miss_i,
  input  logic [TYPE_W-1:0]  acc_type_i,
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic [SET_W-1:0]   hit_set_i,
  input  logic [PID_W-1:0]   pid_i,
  output logic [RAND_W-1:0]  lfsr_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic rst_n_s;

  tvs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  tvs_rand_gen #(.W(RAND_W), .SEED(SEED), .TAPS(TAPS)) u_rand (
    .clk(clk), .rst_n(rst_n_s), .step_i(fault_i), .state_o(lfsr_o)
  );

  tvs_fault_ctx #(
    .SET_W(SET_W), .IDX_W(IDX_W), .VPN_W(VPN_W), .PID_W(PID_W),
    .TYPE_W(TYPE_W), .CAUSE_W(CAUSE_W)
  ) u_ctx (
    .clk(clk), .rst_n(rst_n_s), .fault_i(fault_i), .miss_i(miss_i),
    .rand_set_i(lfsr_o[SET_W-1:0]), .hit_set_i(hit_set_i),
    .vpn_i(vpn_i), .pid_i(pid_i), .acc_type_i(acc_type_i),
    .sel_o(sel_o), .cause_o(cause_o)
  );
endmodule

// File: rtl/tlb_victim_sel_chk.sv
module tlb_victim_sel_chk (
  input logic        clk,
  input logic        rst_n_s,
  input logic        fault_i,
  input logic        miss_i,
  input logic [1:0]  acc_type_i,
  input logic [18:0] vpn_i,
  input logic [1:0]  hit_set_i,
  input logic [7:0]  pid_i,
  input logic [15:0] lfsr_o,
  input logic [5:0]  sel_o,
  input logic [31:0] cause_o
);
  AST_RAND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    lfsr_o != 16'h0); // R2
  AST_RAND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n_s)
    fault_i |=> lfsr_o[14:0] == $past(lfsr_o[15:1])); // R3
  AST_RAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !fault_i |=> $stable(lfsr_o)); // R4
  AST_MISS_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fault_i && miss_i) |=> sel_o[5:4] == $past(lfsr_o[1:0])); // R5
  AST_HIT_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fault_i && !miss_i) |=> sel_o[5:4] == $past(hit_set_i)); // R6
  AST_SEL_INDEX: assert property (@(posedge clk) disable iff (!rst_n_s)
    fault_i |=> sel_o[3:0] == $past(vpn_i[3:0])); // R7
  AST_CAUSE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    fault_i |=> (cause_o[31:13] == $past(vpn_i)) && (cause_o[9:8] == $past(acc_type_i))
                && (cause_o[7:0] == $past(pid_i))); // R8
  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !fault_i |=> $stable(sel_o) && $stable(cause_o)); // R9
  AST_CAUSE_GAP: assert property (@(posedge clk) disable iff (!rst_n_s)
    cause_o[12:10] == 3'b000); // R10
endmodule

bind tlb_victim_sel tlb_victim_sel_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .fault_i(fault_i), .miss_i(miss_i),
  .acc_type_i(acc_type_i), .vpn_i(vpn_i), .hit_set_i(hit_set_i), .pid_i(pid_i),
  .lfsr_o(lfsr_o), .sel_o(sel_o), .cause_o(cause_o)
);

// File: tb/tlb_victim_sel_tb.sv
module tlb_victim_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fault_i, miss_i;
  logic [1:0]  acc_type_i, hit_set_i;
  logic [18:0] vpn_i;
  logic [7:0]  pid_i;
  logic [15:0] lfsr_o;
  logic [5:0]  sel_o;
  logic [31:0] cause_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_rand;
  logic [5:0]  m_sel;
  logic [31:0] m_cause;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlb_victim_sel u_dut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .miss_i(miss_i),
    .acc_type_i(acc_type_i), .vpn_i(vpn_i), .hit_set_i(hit_set_i), .pid_i(pid_i),
    .lfsr_o(lfsr_o), .sel_o(sel_o), .cause_o(cause_o)
  );

  function automatic logic [15:0] next_rand(input logic [15:0] s);
    logic fb = 1'b0;
    for (int i = 0; i < 16; i++) if (s[i] && (16'h8805 >> i) & 1) fb = ~fb; // R2
    return {fb, s[15:1]}; // R3
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one cycle of inputs at a falling edge, then compare after the next rising edge.
  task automatic cycle(input bit f, input bit m, input logic [1:0] t,
                       input logic [18:0] v, input logic [1:0] h, input logic [7:0] p);
    fault_i = f; miss_i = m; acc_type_i = t; vpn_i = v; hit_set_i = h; pid_i = p;
    if (f) begin
      m_sel   = {(m ? m_rand[1:0] : h), v[3:0]};
      m_cause = {v, m_cause[12:10], t, p};
      m_rand  = next_rand(m_rand);
    end
    @(negedge clk);
    chk("R4_R2_R3 rand", {16'h0, lfsr_o}, {16'h0, m_rand});
    chk(f ? (m ? "R5 miss set" : "R6 hit set") : "R9 sel hold", {30'h0, sel_o[5:4]}, {30'h0, m_sel[5:4]});
    chk(f ? "R7 index" : "R9 sel hold", {28'h0, sel_o[3:0]}, {28'h0, m_sel[3:0]});
    chk(f ? "R8 cause" : "R9 cause hold", cause_o, m_cause);
    chk("R10 gap", {29'h0, cause_o[12:10]}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; fault_i = 1'b0; miss_i = 1'b0; acc_type_i = '0;
    vpn_i = '0; hit_set_i = '0; pid_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_rand = 16'hCCCC; m_sel = '0; m_cause = '0;
    chk("R1 rand seed", {16'h0, lfsr_o}, 32'h0000CCCC);
    chk("R1 sel", {26'h0, sel_o}, 32'h0);
    chk("R1 cause", cause_o, 32'h0);
    // Directed: first miss uses set 0 from seed, state becomes 0xE666
    cycle(1, 1, 2'd2, 19'h12345, 2'd3, 8'hA5);
    chk("R3 first step", {16'h0, lfsr_o}, 32'h0000E666);
    chk("R5 first miss sel", {26'h0, sel_o}, {26'h0, 6'h05});
    chk("R8 first cause", cause_o, {19'h12345, 3'b000, 2'd2, 8'hA5});
    // Directed: permission fault uses matched set, state still steps
    cycle(1, 0, 2'd1, 19'h7FFFF, 2'd2, 8'hFF);
    chk("R6 hit sel", {26'h0, sel_o}, {26'h0, 6'h2F});
    // Idle cycles with noisy inputs
    for (int i = 0; i < 4; i++) cycle(0, 1, 2'd3, 19'h0, 2'd1, 8'h00);
    // Back-to-back misses
    for (int i = 0; i < 8; i++) cycle(1, 1, 2'(i), 19'(i * 37), 2'd0, 8'(i));
    // Random mix
    for (int i = 0; i < 3000; i++)
      cycle($urandom_range(0, 1), $urandom_range(0, 1), 2'($urandom), 19'($urandom),
            2'($urandom), 8'($urandom));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule